// File: doc/BRIEF.md
# eMMC Response Frame Receiver

This block listens to the serial command line of an eMMC bus, sampled on the rising edge of the card clock, and turns a device response into parallel fields. The command engine arms it once its command has gone out, and says which kind of response to expect: a 48-bit short frame, a 136-bit long frame, or none. Once armed, the receiver waits for a start bit, shifts in the frame and checks the direction bit, the end bit and the 7-bit CRC. For a short frame it presents the command index and the 32-bit status word. For a long frame it presents the 128-bit register payload.

If no start bit shows up within a fixed window after the arming edge, a timeout pulse is raised instead. Every result is reported by a single-cycle pulse: a valid pulse with its CRC-error and framing-error qualifiers, or a timeout pulse. The decoded fields hold their value until the next frame completes.

Top module: `emmc_rsp_rx`

## Requirements
- R1: After reset, rsp_valid, crc_err, frame_err and timeout are low, and rsp_index, rsp_status and rsp_payload are zero.
- R2: An expect_vld pulse in the idle state arms the receiver when expect_kind is 2'b01 (short, 48 bits) or 2'b10 (long, 136 bits). Kind 2'b00 (none) leaves it idle, so a later frame on the line produces no rsp_valid and no timeout.
- R3: Once armed, the first 0 sampled on cmd_in at a rising edge is taken as the frame's start bit, which is its most significant bit (bit 47 or bit 135).
- R4: If all 64 samples taken at the 64 rising edges after the arming edge are 1, timeout pulses for one cycle right after the 64th edge and the receiver returns to idle. A start bit found on the 64th sample is accepted, with no timeout.
- R5: For a short frame, rsp_valid pulses for one cycle in the cycle after the edge that follows the last bit. rsp_index then shows frame bits [45:40] and rsp_status shows bits [39:8].
- R6: For a long frame, rsp_valid pulses with the same timing. rsp_index shows frame bits [133:128] and rsp_payload shows frame bits [127:0].
- R7: For a short frame, a CRC7 (x^7+x^3+1, register starting at zero, MSB first) is computed over frame bits [47:8]. crc_err is raised alongside rsp_valid when the result differs from bits [7:1].
- R8: For a long frame, the CRC7 covers frame bits [127:8] only and is compared with bits [7:1]. crc_err is reported the same way as for a short frame.
- R9: frame_err is raised alongside rsp_valid when the direction bit (bit 46 of a short frame, bit 134 of a long frame) is not 0, or when the end bit (bit 0) is not 1.
- R10: For a long frame, frame_err is also raised when the index field [133:128] is not all ones.
- R11: An expect_vld pulse that arrives while a frame is awaited or being received is ignored. The frame in progress completes with its original kind.
- R12: rsp_valid and timeout are single-cycle pulses and are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; cmd_in is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| expect_vld | input | 1 | Arm pulse from the command engine |
| expect_kind | input | 2 | Expected response: 00 none, 01 short, 10 long |
| cmd_in | input | 1 | Serial command line, idles high |
| rsp_valid | output | 1 | One-cycle pulse when a frame has been decoded |
| crc_err | output | 1 | CRC mismatch, qualifies rsp_valid |
| frame_err | output | 1 | Direction, end-bit or long-index fault, qualifies rsp_valid |
| timeout | output | 1 | One-cycle pulse when no start bit arrived within the window |
| rsp_index | output | 6 | Index field of the last frame |
| rsp_status | output | 32 | Status word of the last short frame |
| rsp_payload | output | 128 | Low 128 bits of the last long frame |

## Verification
The timeout window and start-bit detection meet on the 64th sample after the arming edge. On that edge the line can show a start bit at the same moment the window counter expires. The bench places the start bit exactly on that sample and expects a clean frame with no timeout, then places it one sample later and expects the timeout pulse at the 65th sampling point and no valid pulse. A second overlap, a new arm request landing in the middle of a frame, is provoked by pulsing expect_vld during reception; it is judged by checking that the frame still decodes as its original kind.

// File: rtl/emmc_rsp_pkg.sv
package emmc_rsp_pkg;
   typedef enum logic [1:0] {
      RK_NONE  = 2'b00,
      RK_SHORT = 2'b01,
      RK_LONG  = 2'b10
   } rsp_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RECV,
      ST_EVAL
   } rx_state_e;
endpackage

// File: rtl/emmc_rsp_crc.sv
module emmc_rsp_crc #(
   parameter int CRC_W = 7,
   parameter logic [CRC_W-1:0] POLY = 7'h09
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             bit_in,
   output logic [CRC_W-1:0] crc
);
   logic fb;
   assign fb = crc[CRC_W-1] ^ bit_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= '0;
      else if (clr)
         crc <= '0;
      else if (en)
         crc <= {crc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end
endmodule

// File: rtl/emmc_rsp_wdog.sv
module emmc_rsp_wdog #(
   parameter int TMO_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic run,
   output logic expire
);
   localparam int CW = (TMO_CYCLES > 1) ? $clog2(TMO_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

   logic [CW-1:0] cnt;

   assign expire = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (run && !expire)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/emmc_rsp_rx.sv
module emmc_rsp_rx
   import emmc_rsp_pkg::*;
#(
   parameter int SHORT_LEN  = 48,
   parameter int LONG_LEN   = 136,
   parameter int HDR_BITS   = 8,
   parameter int IDX_W      = 6,
   parameter int CRC_W      = 7,
   parameter int TMO_CYCLES = 64
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             expect_vld,
   input  logic [1:0]                       expect_kind,
   input  logic                             cmd_in,
   output logic                             rsp_valid,
   output logic                             crc_err,
   output logic                             frame_err,
   output logic                             timeout,
   output logic [IDX_W-1:0]                 rsp_index,
   output logic [SHORT_LEN-HDR_BITS-9:0]    rsp_status,
   output logic [LONG_LEN-HDR_BITS-1:0]     rsp_payload
);
   localparam int TAIL  = CRC_W + 1;
   localparam int STAT_W = SHORT_LEN - HDR_BITS - TAIL;
   localparam int PAY_W = LONG_LEN - HDR_BITS;
   localparam int CNT_W = $clog2(LONG_LEN + 1);
   localparam logic [CNT_W-1:0] SHORT_N = CNT_W'(SHORT_LEN);
   localparam logic [CNT_W-1:0] LONG_N  = CNT_W'(LONG_LEN);

   generate
      if (HDR_BITS != IDX_W + 2) begin : g_bad_hdr
         $error("header must be start, direction and index bits");
      end
      if (LONG_LEN <= SHORT_LEN || SHORT_LEN <= HDR_BITS + TAIL) begin : g_bad_len
         $error("frame lengths inconsistent");
      end
      if (TMO_CYCLES < 2) begin : g_bad_tmo
         $error("timeout window too short");
      end
   endgenerate

   rx_state_e               state;
   logic                    is_long;
   logic [LONG_LEN-1:0]     sr;
   logic [CNT_W-1:0]        bit_cnt;
   logic [CRC_W-1:0]        crc_val;
   logic                    arm, start_seen, tmo_hit, accept, crc_en;
   logic [CNT_W-1:0]        ordinal, frame_n, crc_lo, crc_hi, cnt_next;

   assign arm        = (state == ST_IDLE) && expect_vld &&
                       ((expect_kind == RK_SHORT) || (expect_kind == RK_LONG));
   assign start_seen = (state == ST_WAIT) && !cmd_in;
   assign accept     = start_seen || (state == ST_RECV);
   assign ordinal    = (state == ST_WAIT) ? CNT_W'(1) : bit_cnt + 1'b1;
   assign frame_n    = is_long ? LONG_N : SHORT_N;
   assign crc_lo     = is_long ? CNT_W'(HDR_BITS + 1) : CNT_W'(1);
   assign crc_hi     = frame_n - CNT_W'(TAIL);
   assign crc_en     = accept && (ordinal >= crc_lo) && (ordinal <= crc_hi);
   assign cnt_next   = bit_cnt + 1'b1;

   emmc_rsp_crc #(.CRC_W(CRC_W), .POLY(CRC_W'(7'h09))) crc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (arm),
      .en     (crc_en),
      .bit_in (cmd_in),
      .crc    (crc_val)
   );

   emmc_rsp_wdog #(.TMO_CYCLES(TMO_CYCLES)) wdog_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (arm),
      .run    ((state == ST_WAIT) && cmd_in),
      .expire (tmo_hit)
   );

   // Field extraction from the assembled frame
   logic                 dir_bit, end_bit, idx_bad;
   logic [IDX_W-1:0]     idx_f;
   logic [CRC_W-1:0]     crc_rx;

   always_comb begin
      end_bit = sr[0];
      crc_rx  = sr[CRC_W:1];
      if (is_long) begin
         dir_bit = sr[LONG_LEN-2];
         idx_f   = sr[LONG_LEN-3 -: IDX_W];
         idx_bad = (idx_f != {IDX_W{1'b1}});
      end else begin
         dir_bit = sr[SHORT_LEN-2];
         idx_f   = sr[SHORT_LEN-3 -: IDX_W];
         idx_bad = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         is_long     <= 1'b0;
         sr          <= '0;
         bit_cnt     <= '0;
         rsp_valid   <= 1'b0;
         crc_err     <= 1'b0;
         frame_err   <= 1'b0;
         timeout     <= 1'b0;
         rsp_index   <= '0;
         rsp_status  <= '0;
         rsp_payload <= '0;
      end else begin
         rsp_valid <= 1'b0;
         crc_err   <= 1'b0;
         frame_err <= 1'b0;
         timeout   <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (arm) begin
                  is_long <= (expect_kind == RK_LONG);
                  state   <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (start_seen) begin
                  sr      <= '0;
                  bit_cnt <= CNT_W'(1);
                  state   <= ST_RECV;
               end else if (tmo_hit) begin
                  timeout <= 1'b1;
                  state   <= ST_IDLE;
               end
            end
            ST_RECV: begin
               sr      <= {sr[LONG_LEN-2:0], cmd_in};
               bit_cnt <= cnt_next;
               if (cnt_next == frame_n)
                  state <= ST_EVAL;
            end
            default: begin
               rsp_valid <= 1'b1;
               crc_err   <= (crc_val != crc_rx);
               frame_err <= dir_bit || !end_bit || idx_bad;
               rsp_index <= idx_f;
               if (is_long)
                  rsp_payload <= sr[PAY_W-1:0];
               else
                  rsp_status <= sr[STAT_W+TAIL-1:TAIL];
               state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/emmc_rsp_rx_chk.sv
module emmc_rsp_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rsp_valid,
   input logic       crc_err,
   input logic       frame_err,
   input logic       timeout
);
   assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_timeout_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout);

   assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && timeout));

   assert_crc_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |-> rsp_valid);

   assert_frame_qualified_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> rsp_valid);
endmodule

bind emmc_rsp_rx emmc_rsp_rx_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rsp_valid (rsp_valid),
   .crc_err   (crc_err),
   .frame_err (frame_err),
   .timeout   (timeout)
);

// File: tb/emmc_rsp_rx_tb.sv
module emmc_rsp_rx_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         expect_vld = 1'b0;
   logic [1:0]   expect_kind = 2'b00;
   logic         cmd_in = 1'b1;
   logic         rsp_valid, crc_err, frame_err, timeout;
   logic [5:0]   rsp_index;
   logic [31:0]  rsp_status;
   logic [127:0] rsp_payload;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   emmc_rsp_rx dut_i (
      .clk(clk), .rst_n(rst_n), .expect_vld(expect_vld), .expect_kind(expect_kind),
      .cmd_in(cmd_in), .rsp_valid(rsp_valid), .crc_err(crc_err), .frame_err(frame_err),
      .timeout(timeout), .rsp_index(rsp_index), .rsp_status(rsp_status),
      .rsp_payload(rsp_payload)
   );

   task automatic chk(input logic ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] crc7(input logic [135:0] v, input int hi, input int lo);
      logic [6:0] c = '0;
      for (int i = hi; i >= lo; i--) begin
         logic fb = c[6] ^ v[i];
         c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
      return c;
   endfunction

   function automatic logic [135:0] mk_short(input logic dir, input logic [5:0] idx,
                                             input logic [31:0] st, input logic crc_flip,
                                             input logic endb);
      logic [135:0] f = '0;
      f[47:0] = {1'b0, dir, idx, st, 7'h00, endb};
      f[7:1]  = crc7(f, 47, 8) ^ {6'd0, crc_flip};
      return f;
   endfunction

   function automatic logic [135:0] mk_long(input logic [5:0] idx, input logic [119:0] pl,
                                            input logic crc_flip);
      logic [135:0] f;
      f = {2'b00, idx, pl, 7'h00, 1'b1};
      f[7:1] = crc7(f, 127, 8) ^ {6'd0, crc_flip};
      return f;
   endfunction

   // Arm at a negedge, then drive idle ones and the frame one bit per negedge.
   // poke >= 0 raises a long-kind arm request at that bit slot.
   task automatic run_frame(input logic [1:0] kind, input logic [135:0] f, input int len,
                            input int idle, input int poke);
      @(negedge clk);
      expect_vld  = 1'b1;
      expect_kind = kind;
      for (int i = 0; i < idle + len; i++) begin
         @(negedge clk);
         expect_vld = (i == poke);
         if (i == poke) expect_kind = 2'b10;
         cmd_in = (i < idle) ? 1'b1 : f[len - 1 - (i - idle)];
      end
      @(negedge clk);
      expect_vld = 1'b0;
      cmd_in = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!rsp_valid && !crc_err && !frame_err && !timeout, "R1 flags", 
          {rsp_valid, crc_err, frame_err, timeout}, 0);
      chk(rsp_index == 0 && rsp_status == 0 && rsp_payload == 0, "R1 fields",
          rsp_payload | rsp_status | rsp_index, 0);
   endtask

   task automatic t_short_ok(input int idle, input logic [5:0] idx, input logic [31:0] st);
      run_frame(2'b01, mk_short(1'b0, idx, st, 1'b0, 1'b1), 48, idle, -1);
      chk(rsp_valid && !crc_err && !frame_err && !timeout, "R3 R5 R7 clean short",
          {rsp_valid, crc_err, frame_err, timeout}, 4'b1000);
      chk(rsp_index == idx, "R5 index", rsp_index, idx);
      chk(rsp_status == st, "R5 status", rsp_status, st);
      @(negedge clk);
      chk(!rsp_valid, "R12 valid one cycle", rsp_valid, 0);
   endtask

   task automatic t_short_bad(input logic dir, input logic flip, input logic endb,
                              input string req);
      run_frame(2'b01, mk_short(dir, 6'd13, 32'h0000_0900, flip, endb), 48, 3, -1);
      chk(rsp_valid && crc_err == flip && frame_err == (dir | !endb), req,
          {rsp_valid, crc_err, frame_err}, {1'b1, flip, dir | !endb});
   endtask

   task automatic t_long(input logic [5:0] idx, input logic flip, input logic fe,
                         input string req, input int poke);
      logic [119:0] pl = {30'h2a5_5a5a, 58'h0123_4567_89ab_cde, 32'hdead_beef};
      logic [135:0] f = mk_long(idx, pl, flip);
      run_frame(2'b10, f, 136, 5, poke);
      chk(rsp_valid && crc_err == flip && frame_err == fe, req,
          {rsp_valid, crc_err, frame_err}, {1'b1, flip, fe});
      chk(rsp_payload == f[127:0], "R6 payload", rsp_payload, f[127:0]);
   endtask

   task automatic t_timeout;
      int first = 0;
      @(negedge clk);
      expect_vld = 1'b1;
      expect_kind = 2'b01;
      for (int j = 1; j <= 80; j++) begin
         @(negedge clk);
         expect_vld = 1'b0;
         cmd_in = 1'b1;
         if (timeout && first == 0) first = j;
         if (rsp_valid) chk(1'b0, "R4 no valid on timeout", 1, 0);
      end
      chk(first == 65, "R4 timeout cycle", first, 65);
   endtask

   task automatic t_late_start;
      // start bit one sample past the window: timeout, no frame
      run_frame(2'b01, mk_short(1'b0, 6'd7, 32'h1, 1'b0, 1'b1), 48, 64, -1);
      chk(!rsp_valid, "R4 late start ignored", rsp_valid, 0);
   endtask

   task automatic t_none;
      run_frame(2'b00, mk_short(1'b0, 6'd3, 32'h55, 1'b0, 1'b1), 48, 10, -1);
      chk(!rsp_valid && !timeout, "R2 none kind", {rsp_valid, timeout}, 0);
      repeat (70) begin
         @(negedge clk);
         if (timeout || rsp_valid) chk(1'b0, "R2 none kind quiet", 1, 0);
      end
   endtask

   task automatic t_poke;
      run_frame(2'b01, mk_short(1'b0, 6'd17, 32'hcafe_f00d, 1'b0, 1'b1), 48, 2, 20);
      chk(rsp_valid && !crc_err && !frame_err && rsp_status == 32'hcafe_f00d,
          "R11 arm ignored mid-frame", rsp_status, 32'hcafe_f00d);
      repeat (80) begin
         @(negedge clk);
         if (timeout) chk(1'b0, "R11 no stale arm", 1, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_short_ok(0, 6'd3, 32'h0000_0500);
      t_short_ok(10, 6'd63, 32'hffff_ffff);
      t_short_ok(63, 6'd7, 32'h8000_0001);
      t_short_bad(1'b0, 1'b1, 1'b1, "R7 crc error");
      t_short_bad(1'b1, 1'b0, 1'b1, "R9 direction bit");
      t_short_bad(1'b0, 1'b0, 1'b0, "R9 end bit");
      t_short_bad(1'b1, 1'b1, 1'b1, "R7 R9 both errors");
      t_long(6'h3f, 1'b0, 1'b0, "R6 clean long", -1);
      t_long(6'h3f, 1'b1, 1'b0, "R8 long crc error", -1);
      t_long(6'h02, 1'b0, 1'b1, "R10 long index", -1);
      t_timeout();
      t_late_start();
      t_none();
      t_poke();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule